// File: doc/BRIEF.md
# Recursive Non-Zero Maximum Label Propagator

This block is the core of a streaming connected-component labeller. It takes one pixel label per valid cycle, in column-major scan order: all rows of column 0 from top to bottom, then all rows of column 1, and so on. For every object pixel it emits the largest label found among that pixel and its already-processed neighbours. Each result is written back into the neighbourhood history, so a later pixel in the same pass sees results rather than original inputs. A large label can therefore travel across a whole object in a single pass.

The window is causal and gives 8-connectivity. It holds the pixel just above in the current column and the three pixels of the previous column at the rows above, level with and below the current pixel. A shift line buffer one column plus one pixel long keeps the previous column's results. A row counter and a first-column flag mask every neighbour that falls outside the image. In particular, the bottom of one column never feeds the top of the next.

An outside controller runs passes alternately forward and in reversed pixel order. It pulses the pass-start input before each pass and reads the changed flag at the end of the pass to decide whether labelling has converged. Thresholding and initial labelling happen upstream.

Top module: `nzmax_labeller`

## Requirements
- R1: A valid input label of zero produces an output label of zero, whatever its neighbours hold.
- R2: A valid nonzero input at column c, row r produces the maximum of its own label and the results already produced for (c, r-1), (c-1, r-1), (c-1, r) and (c-1, r+1). Because results are used in place of inputs, a label propagates through a connected run within one pass, including through diagonal contacts.
- R3: At row 0 the neighbours (c, r-1) and (c-1, r-1) read as zero. At row ROWS-1 the neighbour (c-1, r+1) reads as zero. A label at the bottom of a column therefore never reaches the top of the next column.
- R4: For the first column after a pass-start pulse, all previous-column neighbours read as zero, whatever the previous pass left behind.
- R5: out_valid is in_valid delayed by exactly one clock, and out_label carries the result for that pixel in the same cycle. Cycles without in_valid do not advance the row or column position.
- R6: The changed flag goes high one clock after any valid pixel whose result differs from its input label, and then stays high until the next pass-start pulse.
- R7: A pass-start pulse, given in a cycle without in_valid, clears the changed flag on the next clock and makes the next valid pixel column 0, row 0.
- R8: After reset, out_valid and changed are low.
- R9: Feeding a pass's output back in the same order reproduces it unchanged and leaves the changed flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pass_start | input | 1 | One-cycle pulse before each pass; clears the position and the changed flag |
| in_valid | input | 1 | Input label present this cycle |
| in_label | input | LABEL_W | Input label, zero for background |
| out_valid | output | 1 | Result label present this cycle |
| out_label | output | LABEL_W | Result label |
| changed | output | 1 | Some result in this pass differed from its input |

## Verification
The checker assumes that pass_start never coincides with in_valid. It also assumes that input activity starts only after the internal reset release, two clocks after rst_n rises. The stimulus pulses pass_start only in idle cycles and waits out the reset synchroniser before the first pass. Every pass carries whole columns of exactly ROWS pixels, so that the row counter, the column flag and the reference model agree on where each column starts.

// File: rtl/nzmax_pkg.sv
package nzmax_pkg;
  // which neighbours of the causal window are inside the image
  typedef struct packed {
    logic above;      // (c,   r-1)
    logic left_up;    // (c-1, r-1)
    logic left;       // (c-1, r)
    logic left_down;  // (c-1, r+1)
  } nb_mask_t;
endpackage

// File: rtl/nzmax_max2.sv
module nzmax_max2 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb y = (a > b) ? a : b;
endmodule

// File: rtl/nzmax_tree.sv
module nzmax_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] centre,
  input  logic [W-1:0] nb_above,
  input  logic [W-1:0] nb_left_up,
  input  logic [W-1:0] nb_left,
  input  logic [W-1:0] nb_left_down,
  output logic [W-1:0] result
);
  logic [W-1:0] m_a, m_b, m_c, m_tree;

  // four two-input stages form the five-input maximum
  nzmax_max2 #(.W(W)) u_m0 (.a(nb_above),   .b(nb_left_up),   .y(m_a));
  nzmax_max2 #(.W(W)) u_m1 (.a(nb_left),    .b(nb_left_down), .y(m_b));
  nzmax_max2 #(.W(W)) u_m2 (.a(m_a),        .b(m_b),          .y(m_c));
  nzmax_max2 #(.W(W)) u_m3 (.a(m_c),        .b(centre),       .y(m_tree));

  // background stays background
  always_comb result = (centre == '0) ? '0 : m_tree;
endmodule

// File: rtl/nzmax_linebuf.sv
module nzmax_linebuf #(
  parameter int W    = 8,
  parameter int ROWS = 16
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] tap_above,
  output logic [W-1:0] tap_left_up,
  output logic [W-1:0] tap_left,
  output logic [W-1:0] tap_left_down
);
  localparam int DEPTH = ROWS + 1;

  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (en) stage_q[0] <= din;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (en) stage_q[k] <= stage_q[k-1];
    end
  end

  // stage k holds the result produced k+1 pixels ago
  assign tap_above     = stage_q[0];
  assign tap_left_down = stage_q[ROWS-2];
  assign tap_left      = stage_q[ROWS-1];
  assign tap_left_up   = stage_q[ROWS];
endmodule

// File: rtl/nzmax_pos.sv
module nzmax_pos
  import nzmax_pkg::*;
#(
  parameter int ROWS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pass_start,
  input  logic     in_valid,
  output nb_mask_t mask
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d;
  logic             first_col_q, first_col_d;
  logic             row_first, row_last;

  always_comb begin
    row_d       = row_q;
    first_col_d = first_col_q;
    if (pass_start) begin
      row_d       = '0;
      first_col_d = 1'b1;
    end else if (in_valid) begin
      if (row_q == LAST_ROW) begin
        row_d       = '0;
        first_col_d = 1'b0;
      end else begin
        row_d = row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q       <= '0;
      first_col_q <= 1'b1;
    end else begin
      row_q       <= row_d;
      first_col_q <= first_col_d;
    end
  end

  always_comb begin
    row_first      = (row_q == '0);
    row_last       = (row_q == LAST_ROW);
    mask.above     = !row_first;
    mask.left_up   = !first_col_q && !row_first;
    mask.left      = !first_col_q;
    mask.left_down = !first_col_q && !row_last;
  end
endmodule

// File: rtl/nzmax_labeller.sv
module nzmax_labeller
  import nzmax_pkg::*;
#(
  parameter int LABEL_W = 8,
  parameter int ROWS    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pass_start,
  input  logic               in_valid,
  input  logic [LABEL_W-1:0] in_label,
  output logic               out_valid,
  output logic [LABEL_W-1:0] out_label,
  output logic               changed
);
  logic               rst_meta_q, rst_sync_q;
  nb_mask_t           mask;
  logic [LABEL_W-1:0] raw_above, raw_lu, raw_l, raw_ld;
  logic [LABEL_W-1:0] nb_above, nb_lu, nb_l, nb_ld;
  logic [LABEL_W-1:0] result;
  logic               valid_q;
  logic [LABEL_W-1:0] label_q, label_d;
  logic               changed_q, changed_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  nzmax_pos #(.ROWS(ROWS)) u_pos (
    .clk(clk), .rst_n(rst_sync_q), .pass_start(pass_start),
    .in_valid(in_valid), .mask(mask)
  );

  nzmax_linebuf #(.W(LABEL_W), .ROWS(ROWS)) u_lbuf (
    .clk(clk), .en(in_valid), .din(result),
    .tap_above(raw_above), .tap_left_up(raw_lu),
    .tap_left(raw_l), .tap_left_down(raw_ld)
  );

  always_comb begin
    nb_above = mask.above     ? raw_above : '0;
    nb_lu    = mask.left_up   ? raw_lu    : '0;
    nb_l     = mask.left      ? raw_l     : '0;
    nb_ld    = mask.left_down ? raw_ld    : '0;
  end

  nzmax_tree #(.W(LABEL_W)) u_tree (
    .centre(in_label), .nb_above(nb_above), .nb_left_up(nb_lu),
    .nb_left(nb_l), .nb_left_down(nb_ld), .result(result)
  );

  always_comb begin
    label_d   = in_valid ? result : label_q;
    changed_d = pass_start ? 1'b0
              : (changed_q || (in_valid && (result != in_label)));
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      valid_q   <= 1'b0;
      label_q   <= '0;
      changed_q <= 1'b0;
    end else begin
      valid_q   <= in_valid;
      label_q   <= label_d;
      changed_q <= changed_d;
    end
  end

  assign out_valid = valid_q;
  assign out_label = label_q;
  assign changed   = changed_q;
endmodule

// File: rtl/nzmax_labeller_chk.sv
module nzmax_labeller_chk #(
  parameter int LABEL_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pass_start,
  input logic               in_valid,
  input logic [LABEL_W-1:0] in_label,
  input logic               out_valid,
  input logic [LABEL_W-1:0] out_label,
  input logic               changed
);
  // environment rule behind R7
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start |-> !in_valid);

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_zero_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_label == '0) |=> (out_label == '0));

  p_never_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_label != '0) |=> (out_label >= $past(in_label)));

  p_change_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_label != $past(in_label)) -> changed));

  p_change_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && !pass_start) |=> changed);

  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start |=> !changed);
endmodule

bind nzmax_labeller nzmax_labeller_chk #(.LABEL_W(LABEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .in_valid(in_valid),
  .in_label(in_label), .out_valid(out_valid), .out_label(out_label),
  .changed(changed)
);

// File: tb/nzmax_labeller_bench.sv
module nzmax_labeller_bench;
  localparam int W     = 8;
  localparam int ROWS  = 5;
  localparam int MAXPX = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pass_start;
  logic         in_valid;
  logic [W-1:0] in_label;
  logic         out_valid;
  logic [W-1:0] out_label;
  logic         changed;

  int checks = 0;
  int errors = 0;
  int img  [MAXPX];
  int expv [MAXPX];

  always #2.5 clk = ~clk;

  nzmax_labeller #(.LABEL_W(W), .ROWS(ROWS)) u_nzmax_labeller (
    .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .in_valid(in_valid),
    .in_label(in_label), .out_valid(out_valid), .out_label(out_label),
    .changed(changed)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rd(input int c, input int r);
    if (c < 0 || r < 0 || r >= ROWS) return 0;
    return expv[c*ROWS + r];
  endfunction

  // reference rule, written from the requirements
  task automatic model(input int cols);
    for (int c = 0; c < cols; c++)
      for (int r = 0; r < ROWS; r++) begin
        int m;
        m = img[c*ROWS + r];
        if (m != 0) begin
          if (rd(c, r-1)   > m) m = rd(c, r-1);
          if (rd(c-1, r-1) > m) m = rd(c-1, r-1);
          if (rd(c-1, r)   > m) m = rd(c-1, r);
          if (rd(c-1, r+1) > m) m = rd(c-1, r+1);
        end
        expv[c*ROWS + r] = m;
      end
  endtask

  task automatic clear_img();
    for (int i = 0; i < MAXPX; i++) img[i] = 0;
  endtask

  // one pass: pulse start, stream pixels, compare each result
  task automatic run_pass(input int cols, input bit gaps, input string req);
    bit exp_chg;
    exp_chg = 1'b0;
    model(cols);
    @(negedge clk);
    pass_start = 1'b1;
    @(negedge clk);
    pass_start = 1'b0;
    check("R7 changed cleared", changed, 0);
    for (int i = 0; i < cols*ROWS; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        check("R5 idle gives no valid", out_valid, 0);
      end
      in_valid = 1'b1;
      in_label = W'(img[i]);
      if (img[i] != expv[i]) exp_chg = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R5 valid latency", out_valid, 1);
      check(req, out_label, expv[i]);
    end
    check("R6 changed flag", changed, exp_chg);
  endtask

  task automatic t_reset();
    check("R8 out_valid after reset", out_valid, 0);
    check("R8 changed after reset", changed, 0);
  endtask

  task automatic t_single();
    clear_img();
    img[1*ROWS + 1] = 3;
    img[1*ROWS + 2] = 7;
    img[2*ROWS + 1] = 0;
    run_pass(3, 1'b0, "R1 R2 column merge");
    check("R1 zero beside object", expv[2*ROWS+1], 0);
  endtask

  task automatic t_wrap();
    clear_img();
    img[0*ROWS + ROWS-1] = 9;
    img[1*ROWS + 0]      = 2;
    img[3*ROWS + 0]      = 8;
    img[3*ROWS + ROWS-1] = 4;
    run_pass(4, 1'b0, "R3 no wraparound");
    check("R3 top of column kept", expv[1*ROWS], 2);
  endtask

  task automatic t_diag();
    clear_img();
    img[0*ROWS + 0] = 3;
    img[1*ROWS + 1] = 6;
    img[2*ROWS + 0] = 1;
    img[0*ROWS + 3] = 9;
    for (int c = 1; c < 5; c++) img[c*ROWS + 3] = 1;
    run_pass(5, 1'b0, "R2 diagonal and run");
  endtask

  task automatic t_first_col();
    clear_img();
    for (int r = 0; r < ROWS; r++) img[2*ROWS + r] = 9;
    run_pass(3, 1'b0, "R2 fill last column");
    clear_img();
    for (int r = 0; r < ROWS; r++) img[r] = 1;
    run_pass(1, 1'b0, "R4 first column isolated");
  endtask

  task automatic t_random(input int rounds);
    for (int k = 0; k < rounds; k++) begin
      for (int i = 0; i < 8*ROWS; i++)
        img[i] = ($urandom % 2 == 0) ? 0 : int'(1 + $urandom % 200);
      run_pass(8, 1'b1, "R2 random image");
      // second identical pass on the result
      for (int i = 0; i < 8*ROWS; i++) img[i] = expv[i];
      run_pass(8, 1'b1, "R9 repeat pass stable");
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pass_start = 1'b0;
    in_valid = 1'b0;
    in_label = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_diag();
    t_first_col();
    t_random(6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule